// File: doc/BRIEF.md
# Display Serial Command/Data Transmitter

This block moves a stream of command and data bytes to a display panel over a serial bus. Each byte arrives through a valid/ready handshake. A flag marks the byte as command or data, and a second flag marks the last byte of a transaction. The block shapes each byte into one serial word and shifts it out MSB first. It drives a serial clock, a data line, an active-low chip select and, in the 4-wire framings, a separate command/data pin.

There are three framings. The 3-wire framing puts the command/data flag in front of the byte, so each word is 9 clocks long. The 4-wire framing sends the bare byte in 8 clocks and shows the flag on the command/data pin. The wide 4-wire framing sends 16 clocks per word: eight stuffing zeros, then the byte. A divider input sets the length of each half-period of the serial clock in system clock cycles.

Chip select falls with the first accepted byte. It stays low across every word of the transaction, even when the next byte is late. It rises one half-period after the final falling clock edge of the word that carries the last marker. The configuration is taken only while chip select is high.

Top module: `dsp_ser_tx`

## Requirements
- R1: With `cfg_mode` = 1 (3-wire), each word is 9 serial clocks. The bit at the first rising edge is the flag (1 = data, 0 = command), followed by byte bits 7 down to 0. `cd` reads 0 while chip select is low.
- R2: With `cfg_mode` = 2 (4-wire) and `cfg_xfer` other than 16, each word is 8 serial clocks carrying byte bits 7 down to 0. `cd` is 1 for a data byte and 0 for a command byte.
- R3: `cd` changes only on the clock cycle after a byte is accepted. It holds its value for the whole word and until the next accepted byte.
- R4: `csn` falls when the first byte is accepted. It stays low across all words up to the word marked last, with no high pulse between words, even if the next byte arrives late. `sck` never rises while `csn` is high.
- R5: With `cfg_mode` = 2 and `cfg_xfer` = 16, each word is 16 serial clocks: eight 0 bits, then byte bits 7 down to 0. In 3-wire mode `cfg_xfer` has no effect.
- R6: `sck` idles low, and `sdo` changes only while `sck` is low. Each high phase lasts `cfg_div`+1 system clock cycles, and the first rising edge comes `cfg_div`+1 cycles after `csn` falls.
- R7: `csn` rises exactly `cfg_div`+1 system clock cycles after the last falling `sck` edge of the word marked last.
- R8: `in_ready` is high only while idle or between words. It is never high while `sck` is high or during the hold time before `csn` rises. A byte is taken on a cycle with both `in_valid` and `in_ready` high.
- R9: `cfg_mode`, `cfg_xfer` and `cfg_div` are sampled only while `csn` is high. Changes while `csn` is low do not alter the transaction in progress.
- R10: After synchronous reset: `csn` = 1, `sck` = 0, `sdo` = 0, `cd` = 0 and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | Framing mode: 1 = 3-wire, 2 = 4-wire |
| cfg_xfer | input | 5 | Word size in 4-wire mode: 16 = wide word, else 8 |
| cfg_div | input | DIV_W | Half-period of the serial clock, minus one, in system cycles |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block takes the offered byte this cycle |
| in_byte | input | 8 | Byte to send |
| in_is_data | input | 1 | 1 = data byte, 0 = command byte |
| in_last | input | 1 | Byte ends the transaction |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out, MSB first |
| csn | output | 1 | Active-low chip select |
| cd | output | 1 | Command/data pin for the 4-wire framings |

## Verification
On every cycle, the assertions check these rules: the clock pulses only inside chip select, the data line holds still while the clock is high, the command/data pin moves only on an accepted byte, the handshake is closed during high phases, the 3-wire framing keeps the pin low, the configuration is frozen under chip select, and the reset state. Some behaviour only the bench scenarios can show, because it needs a whole serial word rebuilt from the pins. That covers the bit order and stuffing of each framing, the exact setup, high and hold lengths for several divider values, chip select holding low across late bytes, and the stream staying intact when the configuration changes mid-transaction.

// File: rtl/dsp_ser_pkg.sv
package dsp_ser_pkg;

    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 2 * BYTE_W;
    localparam int CNT_W   = $clog2(FRAME_W) + 1;

    localparam logic [1:0] MODE_3W = 2'd1;
    localparam logic [4:0] XFER_WIDE = 5'd16;

    typedef enum logic [1:0] {
        FMT_3W   = 2'd0,
        FMT_4W8  = 2'd1,
        FMT_4W16 = 2'd2
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LO   = 3'd1,
        ST_HI   = 3'd2,
        ST_GAP  = 3'd3,
        ST_HOLD = 3'd4
    } state_e;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [CNT_W-1:0]   nbits;
        logic               cd;
    } frame_t;

    function automatic fmt_e decode_fmt(input logic [1:0] mode, input logic [4:0] xfer);
        if (mode == MODE_3W)
            return FMT_3W;
        else if (xfer == XFER_WIDE)
            return FMT_4W16;
        else
            return FMT_4W8;
    endfunction

    function automatic frame_t build_frame(input fmt_e fmt, input logic [BYTE_W-1:0] b,
                                           input logic is_data);
        frame_t f;
        f.bits  = '0;
        f.nbits = CNT_W'(BYTE_W);
        f.cd    = is_data;
        case (fmt)
            FMT_3W: begin
                f.bits  = ({is_data, b, {(FRAME_W-BYTE_W-1){1'b0}}});
                f.nbits = CNT_W'(BYTE_W + 1);
                f.cd    = 1'b0;
            end
            FMT_4W16: begin
                f.bits  = FRAME_W'(b);
                f.nbits = CNT_W'(FRAME_W);
            end
            default: begin
                f.bits  = {b, {(FRAME_W-BYTE_W){1'b0}}};
                f.nbits = CNT_W'(BYTE_W);
            end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/dsp_ser_cfg.sv
module dsp_ser_cfg
    import dsp_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             open_i,
    input  logic [1:0]       mode_i,
    input  logic [4:0]       xfer_i,
    input  logic [DIV_W-1:0] div_i,
    output fmt_e             fmt_o,
    output logic [DIV_W-1:0] div_o
);

    fmt_e             fmt_q;
    logic [DIV_W-1:0] div_q;
    fmt_e             fmt_live;

    assign fmt_live = decode_fmt(mode_i, xfer_i);

    // Settings follow the inputs while the bus is idle and freeze otherwise.
    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= FMT_4W8;
            div_q <= '0;
        end else if (open_i) begin
            fmt_q <= fmt_live;
            div_q <= div_i;
        end
    end

    assign fmt_o = open_i ? fmt_live : fmt_q;
    assign div_o = open_i ? div_i : div_q;

endmodule

// File: rtl/dsp_ser_tick.sv
module dsp_ser_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [DIV_W-1:0] lim_i,
    output logic             done_o
);

    logic [DIV_W-1:0] cnt_q;

    // Counts one half-period; wraps to zero so phases chain back to back.
    always_ff @(posedge clk) begin
        if (rst || !run_i)
            cnt_q <= '0;
        else if (cnt_q == lim_i)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = run_i && (cnt_q == lim_i);

endmodule

// File: rtl/dsp_ser_frame.sv
module dsp_ser_frame
    import dsp_ser_pkg::*;
(
    input  fmt_e              fmt_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              is_data_i,
    output frame_t            frame_o
);

    always_comb begin
        frame_o = build_frame(fmt_i, byte_i, is_data_i);
    end

endmodule

// File: rtl/dsp_ser_tx.sv
module dsp_ser_tx
    import dsp_ser_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_mode,
    input  logic [4:0]       cfg_xfer,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    input  logic             in_is_data,
    input  logic             in_last,
    output logic             sck,
    output logic             sdo,
    output logic             csn,
    output logic             cd
);

    state_e             state_q;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic               last_q;
    logic               cd_q;

    fmt_e               act_fmt;
    logic [DIV_W-1:0]   act_div;
    frame_t             frm;
    logic               cfg_open;
    logic               ph_run;
    logic               ph_done;
    logic               fire;

    assign cfg_open = (state_q == ST_IDLE);
    assign in_ready = (state_q == ST_IDLE) || (state_q == ST_GAP);
    assign fire     = in_valid && in_ready;
    assign ph_run   = (state_q == ST_LO) || (state_q == ST_HI) || (state_q == ST_HOLD);

    dsp_ser_cfg #(.DIV_W(DIV_W)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .open_i (cfg_open),
        .mode_i (cfg_mode),
        .xfer_i (cfg_xfer),
        .div_i  (cfg_div),
        .fmt_o  (act_fmt),
        .div_o  (act_div)
    );

    dsp_ser_frame u_frame (
        .fmt_i     (act_fmt),
        .byte_i    (in_byte),
        .is_data_i (in_is_data),
        .frame_o   (frm)
    );

    dsp_ser_tick #(.DIV_W(DIV_W)) u_tick (
        .clk    (clk),
        .rst    (rst),
        .run_i  (ph_run),
        .lim_i  (act_div),
        .done_o (ph_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
            last_q  <= 1'b0;
            cd_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE, ST_GAP: begin
                    if (fire) begin
                        shreg_q <= frm.bits;
                        left_q  <= frm.nbits - 1'b1;
                        last_q  <= in_last;
                        cd_q    <= frm.cd;
                        state_q <= ST_LO;
                    end
                end
                ST_LO: begin
                    if (ph_done)
                        state_q <= ST_HI;
                end
                ST_HI: begin
                    if (ph_done) begin
                        if (left_q == '0) begin
                            state_q <= last_q ? ST_HOLD : ST_GAP;
                        end else begin
                            shreg_q <= shreg_q << 1;
                            left_q  <= left_q - 1'b1;
                            state_q <= ST_LO;
                        end
                    end
                end
                ST_HOLD: begin
                    if (ph_done)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign sck = (state_q == ST_HI);
    assign csn = (state_q == ST_IDLE);
    assign sdo = shreg_q[FRAME_W-1];
    assign cd  = cd_q;

endmodule

// File: rtl/dsp_ser_tx_chk.sv
module dsp_ser_tx_chk
    import dsp_ser_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic sck,
    input logic sdo,
    input logic csn,
    input logic cd,
    input fmt_e act_fmt
);

    p_sck_in_csn_r4: assert property (@(posedge clk) disable iff (rst)
        sck |-> !csn);

    p_ready_clock_low_r8: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !sck);

    p_cd_on_accept_r3: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(cd));

    p_sdo_hold_high_r6: assert property (@(posedge clk) disable iff (rst)
        sck |=> (!sck || $stable(sdo)));

    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        !csn |=> (csn || $stable(act_fmt)));

    p_cd_low_3w_r1: assert property (@(posedge clk) disable iff (rst)
        (!csn && act_fmt == FMT_3W) |-> !cd);

    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (csn && !sck && !cd && in_ready));

endmodule

bind dsp_ser_tx dsp_ser_tx_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .sck      (sck),
    .sdo      (sdo),
    .csn      (csn),
    .cd       (cd),
    .act_fmt  (act_fmt)
);

// File: tb/test_dsp_ser_tx.sv
module test_dsp_ser_tx;
    localparam int DIV_W = 8;
    localparam int MAXB  = 512;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_mode = 2'd2;
    logic [4:0]       cfg_xfer = 5'd8;
    logic [DIV_W-1:0] cfg_div = '0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [7:0]       in_byte = '0;
    logic             in_is_data = 1'b0;
    logic             in_last = 1'b0;
    logic             sck, sdo, csn, cd;

    always #2 clk = ~clk;

    dsp_ser_tx #(.DIV_W(DIV_W)) i_dsp_ser_tx (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_xfer(cfg_xfer), .cfg_div(cfg_div),
        .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte), .in_is_data(in_is_data),
        .in_last(in_last), .sck(sck), .sdo(sdo), .csn(csn), .cd(cd)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Expected stream, built from the requirements.
    logic exp_bit [MAXB];
    logic exp_cd  [MAXB];
    int   exp_n = 0;
    int   exp_h = 1;
    int   exp_fmt = 1;

    logic got_bit [MAXB];
    logic got_cd  [MAXB];
    int   got_n = 0;

    int   txn_seen = 0;
    int   last_mism = 0;
    logic p_sck = 1'b0;
    logic p_csn = 1'b1;
    int   hi_run = 0;
    int   lo_run = 0;
    logic hi_sdo = 1'b0;
    bit   first_rise = 1'b0;

    function automatic string fmt_tag(input int f);
        if (f == 0) return "R1";
        if (f == 2) return "R5";
        return "R2";
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (p_csn && !csn) begin
                got_n = 0;
                lo_run = 0;
                first_rise = 1'b1;
            end
            if (sck && !p_sck) begin
                if (first_rise)
                    check(lo_run == exp_h, "R6 setup before first rise", lo_run, exp_h);
                first_rise = 1'b0;
                if (got_n < MAXB) begin
                    got_bit[got_n] = sdo;
                    got_cd[got_n]  = cd;
                end
                got_n++;
                hi_run = 0;
                hi_sdo = sdo;
            end
            if (sck) begin
                hi_run++;
                check(sdo == hi_sdo, "R6 sdo moved while sck high", int'(sdo), int'(hi_sdo));
                check(!in_ready, "R8 ready during high phase", int'(in_ready), 0);
                check(!csn, "R4 clock pulse outside csn", int'(csn), 0);
            end
            if (!sck && p_sck) begin
                check(hi_run == exp_h, "R6 high phase length", hi_run, exp_h);
                lo_run = 0;
            end
            if (!sck && !csn) lo_run++;
            if (csn && !p_csn) begin
                int mism;
                int cmism;
                mism = 0;
                cmism = 0;
                check(lo_run == exp_h, "R7 hold before csn rise", lo_run, exp_h);
                check(got_n == exp_n, "R4 clocks inside one csn low", got_n, exp_n);
                for (int i = 0; i < exp_n && i < MAXB; i++) begin
                    if (got_bit[i] !== exp_bit[i]) mism++;
                    if (got_cd[i] !== exp_cd[i]) cmism++;
                end
                check(mism == 0, fmt_tag(exp_fmt), mism, 0);
                check(cmism == 0, "R3 cd per word", cmism, 0);
                last_mism = mism + cmism + ((got_n == exp_n) ? 0 : 1);
                txn_seen++;
            end
        end
        p_sck = sck;
        p_csn = csn;
    end

    task automatic push_exp(input int fmt, input logic [7:0] b, input logic d);
        if (fmt == 0) begin
            exp_bit[exp_n] = d; exp_cd[exp_n] = 1'b0; exp_n++;
        end else if (fmt == 2) begin
            for (int k = 0; k < 8; k++) begin
                exp_bit[exp_n] = 1'b0; exp_cd[exp_n] = d; exp_n++;
            end
        end
        for (int k = 7; k >= 0; k--) begin
            exp_bit[exp_n] = b[k];
            exp_cd[exp_n]  = (fmt == 0) ? 1'b0 : d;
            exp_n++;
        end
    endtask

    task automatic send(input logic [7:0] b, input logic d, input logic l, input int gap);
        @(negedge clk);
        in_valid = 1'b1; in_byte = b; in_is_data = d; in_last = l;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic run_txn(input int mode, input int xfer, input int div, input int nb,
                           input int gap, input bit swap, input int seed);
        int fmt;
        int seen0;
        logic [7:0] b;
        logic d;
        fmt = (mode == 1) ? 0 : ((xfer == 16) ? 2 : 1);
        @(negedge clk);
        cfg_mode = 2'(mode); cfg_xfer = 5'(xfer); cfg_div = DIV_W'(div);
        exp_n = 0; exp_h = div + 1; exp_fmt = fmt;
        seen0 = txn_seen;
        for (int i = 0; i < nb; i++) begin
            b = 8'((seed * 37 + i * 91 + mode * 13 + xfer + 5) & 255);
            if (i == 1) b = 8'hFF;
            if (i == 2) b = 8'h00;
            d = 1'((i + seed) % 2);
            push_exp(fmt, b, d);
        end
        for (int i = 0; i < nb; i++) begin
            b = 8'((seed * 37 + i * 91 + mode * 13 + xfer + 5) & 255);
            if (i == 1) b = 8'hFF;
            if (i == 2) b = 8'h00;
            d = 1'((i + seed) % 2);
            send(b, d, (i == nb - 1), gap);
            if (swap && i == 0) begin
                cfg_mode = (mode == 1) ? 2'd2 : 2'd1;
                cfg_xfer = 5'd16;
                cfg_div  = DIV_W'(div + 2);
            end
        end
        while (txn_seen == seen0) @(negedge clk);
        if (swap) check(last_mism == 0, "R9 cfg change under csn", last_mism, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int seed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(csn == 1'b1, "R10 csn after reset", int'(csn), 1);
        check(sck == 1'b0, "R10 sck after reset", int'(sck), 0);
        check(sdo == 1'b0, "R10 sdo after reset", int'(sdo), 0);
        check(cd == 1'b0, "R10 cd after reset", int'(cd), 0);
        check(in_ready == 1'b1, "R10 ready after reset", int'(in_ready), 1);
        seed = 1;
        foreach (cfg_mode_list[m]) begin
            for (int x = 0; x < 2; x++) begin
                for (int v = 0; v < 3; v++) begin
                    for (int n = 0; n < 2; n++) begin
                        int dv;
                        int nbytes;
                        dv = (v == 0) ? 0 : ((v == 1) ? 1 : 3);
                        nbytes = (n == 0) ? 1 : 3;
                        run_txn(cfg_mode_list[m], (x == 0) ? 8 : 16, dv, nbytes,
                                (nbytes == 3 && dv == 1) ? 5 : 0, 1'b0, seed);
                        seed++;
                    end
                end
            end
        end
        run_txn(2, 8, 1, 3, 2, 1'b1, 40);
        run_txn(1, 8, 0, 3, 0, 1'b1, 41);
        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

    int cfg_mode_list [2] = '{1, 2};

endmodule